// File: doc/BRIEF.md
# Simple Vectored Interrupt Controller

This block is the interrupt facility of a small processor core. It has one enable flag and no priority logic. An external device raises a request and supplies an 8-bit type code and a 16-bit information word. The request is taken only at an instruction fetch boundary while the enable flag is set. When it is taken, the block does four things in the same cycle:

- it records the current program counter and the device information word;
- it clears the enable flag;
- it pulses an acknowledge line back to the device;
- it tells the core to load its program counter with a handler address built from the type code.

The core also passes in the decoded interrupt-control instructions with their register operands. The block applies the register effects of these instructions:

- return from handler: restore the program counter and set the enable flag, in one indivisible step;
- enable interrupts;
- disable interrupts;
- save state: present the saved PC and the information word for write-back to two registers;
- restore state: load the saved PC and the information word from two register values.

If an interrupt is taken in the same cycle as a command, the interrupt entry has precedence.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the enable flag reads 0, the saved PC reads 0, the information register reads 0, and `irq_ack` and `pc_load` are 0.
- R2: A request is taken in a cycle exactly when `fetch_start`, `irq_req` and the enable flag are all 1. In that cycle `irq_ack` and `pc_load` are 1, and `pc_next` is 20 zero bits, then `irq_type` in bits 11..4, then 4 zero bits in bits 3..0.
- R3: In the cycle after a request is taken, `sv_pc` equals the `pc_cur` of the entry cycle, `sv_info` equals the `irq_info` of the entry cycle, and `int_en` is 0.
- R4: `irq_ack` is high for a single cycle per entry and is 0 in the cycle after it was 1.
- R5: While the enable flag is 0, a request together with `fetch_start` is ignored: `irq_ack` and `pc_load` stay 0, and the saved PC and information register keep their values.
- R6: A request without `fetch_start` is ignored, whatever the state of the enable flag.
- R7: A command with `cmd_op` = 29 (return from handler) drives `pc_load` = 1 and `pc_next` = saved PC in its own cycle, and `int_en` is 1 from the next cycle.
- R8: A command with `cmd_op` = 10 sets the enable flag, and one with `cmd_op` = 11 clears it, from the next cycle.
- R9: A command with `cmd_op` = 16 (save state) drives `sv_valid` = 1 in its cycle, with `sv_info` and `sv_pc` holding the current register values.
- R10: A command with `cmd_op` = 17 (restore state) loads the information register from `cmd_a` and the saved PC from `cmd_b`, visible from the next cycle.
- R11: Other opcodes have no effect, and a command with `cmd_valid` = 0 has no effect. A command in the same cycle as an interrupt entry is dropped, and the entry takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request from the device |
| irq_type | input | 8 | Device type code used to form the handler address |
| irq_info | input | 16 | Device information word |
| irq_ack | output | 1 | Acknowledge pulse to the device |
| fetch_start | input | 1 | Core is at an instruction fetch boundary |
| cmd_valid | input | 1 | An interrupt-control command is present |
| cmd_op | input | 5 | Opcode of the command |
| cmd_a | input | 16 | Low half of the first register operand |
| cmd_b | input | 32 | Second register operand |
| pc_cur | input | 32 | Current program counter |
| pc_load | output | 1 | Core must load `pc_next` into its program counter |
| pc_next | output | 32 | New program counter value |
| int_en | output | 1 | Enable flag |
| sv_valid | output | 1 | Save-state data is valid for write-back |
| sv_info | output | 16 | Stored information word |
| sv_pc | output | 32 | Stored program counter |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:

- A request with the flag clear, or a request held between fetch boundaries. A design that ignores either gate would enter the handler twice or while disabled, and overwrite the saved PC.
- A return from handler arriving in the same cycle as a fetch boundary with a request pending. A design that lets the new enable value act at once would re-enter in the same cycle.
- An entry in the same cycle as an enable command. A design that orders these wrongly would leave the flag set inside the handler.
- The type codes 0x00 and 0xFF. A design that misplaces the shifted type code would show a wrong `pc_next`.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int PC_W   = 32,
  parameter int INFO_W = 16,
  parameter int TYPE_W = 8,
  parameter int OP_W   = 5,
  parameter int OP_RFI = 29,
  parameter int OP_EEN = 10,
  parameter int OP_EDI = 11,
  parameter int OP_SVI = 16,
  parameter int OP_RI  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [TYPE_W-1:0] irq_type,
  input  logic [INFO_W-1:0] irq_info,
  output logic              irq_ack,
  input  logic              fetch_start,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [INFO_W-1:0] cmd_a,
  input  logic [PC_W-1:0]   cmd_b,
  input  logic [PC_W-1:0]   pc_cur,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_next,
  output logic              int_en,
  output logic              sv_valid,
  output logic [INFO_W-1:0] sv_info,
  output logic [PC_W-1:0]   sv_pc
);
  localparam int LO_W = 4;
  localparam int HI_W = PC_W - TYPE_W - LO_W;

  logic              en_q;
  logic [PC_W-1:0]   spc_q;
  logic [INFO_W-1:0] info_q;
  logic              take, go;
  logic              is_rfi, is_een, is_edi, is_svi, is_ri;
  logic [PC_W-1:0]   vec_addr;

  assign take   = fetch_start & irq_req & en_q;
  assign go     = cmd_valid & ~take;
  assign is_rfi = go & (cmd_op == OP_W'(OP_RFI));
  assign is_een = go & (cmd_op == OP_W'(OP_EEN));
  assign is_edi = go & (cmd_op == OP_W'(OP_EDI));
  assign is_svi = go & (cmd_op == OP_W'(OP_SVI));
  assign is_ri  = go & (cmd_op == OP_W'(OP_RI));

  assign vec_addr = {{HI_W{1'b0}}, irq_type, {LO_W{1'b0}}};

  assign irq_ack  = take;
  assign pc_load  = take | is_rfi;
  assign pc_next  = take ? vec_addr : spc_q;
  assign int_en   = en_q;
  assign sv_valid = is_svi;
  assign sv_info  = info_q;
  assign sv_pc    = spc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      spc_q  <= '0;
      info_q <= '0;
    end else if (take) begin
      en_q   <= 1'b0;
      spc_q  <= pc_cur;
      info_q <= irq_info;
    end else begin
      if (is_rfi || is_een) en_q <= 1'b1;
      else if (is_edi)      en_q <= 1'b0;
      if (is_ri) begin
        spc_q  <= cmd_b;
        info_q <= cmd_a;
      end
    end
  end
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic [7:0]  irq_type,
  input logic [15:0] irq_info,
  input logic        irq_ack,
  input logic        fetch_start,
  input logic        cmd_valid,
  input logic [4:0]  cmd_op,
  input logic [15:0] cmd_a,
  input logic [31:0] cmd_b,
  input logic [31:0] pc_cur,
  input logic        pc_load,
  input logic [31:0] pc_next,
  input logic        int_en,
  input logic        sv_valid,
  input logic [15:0] sv_info,
  input logic [31:0] sv_pc
);
  p_take_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (fetch_start && irq_req && int_en));
  p_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (pc_load && pc_next == {20'b0, irq_type, 4'b0}));
  p_entry_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!int_en && sv_pc == $past(pc_cur) && sv_info == $past(irq_info)));
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq_ack);
  p_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_start |-> !irq_ack);
  p_rfi_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 5'd29 && !irq_ack) |-> (pc_load && pc_next == sv_pc));
  p_rfi_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 5'd29 && !irq_ack) |=> int_en);
  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 5'd11 && !irq_ack) |=> !int_en);
  p_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sv_valid |-> (cmd_valid && cmd_op == 5'd16));
  p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 5'd17 && !irq_ack) |=>
      (sv_info == $past(cmd_a) && sv_pc == $past(cmd_b)));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_ack && !cmd_valid) |=> ($stable(sv_pc) && $stable(sv_info) && $stable(int_en)));
endmodule

bind irq_vector_unit irq_vector_chk u_chk (.*);

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [7:0]  irq_type = '0;
  logic [15:0] irq_info = '0;
  logic        irq_ack;
  logic        fetch_start = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_op = '0;
  logic [15:0] cmd_a = '0;
  logic [31:0] cmd_b = '0;
  logic [31:0] pc_cur = '0;
  logic        pc_load;
  logic [31:0] pc_next;
  logic        int_en;
  logic        sv_valid;
  logic [15:0] sv_info;
  logic [31:0] sv_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          m_en;
  logic [31:0] m_spc;
  logic [15:0] m_info;

  always #2 clk = ~clk;

  irq_vector_unit dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive inputs before calling; compares before the edge, then updates model
  task automatic cycle(input string tag);
    bit take, go, e_load, e_sv;
    logic [31:0] e_next;
    #1;
    take   = fetch_start && irq_req && m_en;
    go     = cmd_valid && !take;
    e_load = take || (go && cmd_op == 5'd29);
    e_next = take ? (32'(irq_type) << 4) : m_spc;
    e_sv   = go && cmd_op == 5'd16;
    chk(irq_ack == take, tag, "irq_ack", 32'(irq_ack), 32'(take));
    chk(pc_load == e_load, tag, "pc_load", 32'(pc_load), 32'(e_load));
    if (e_load) chk(pc_next == e_next, tag, "pc_next", pc_next, e_next);
    chk(int_en == m_en, tag, "int_en", 32'(int_en), 32'(m_en));
    chk(sv_valid == e_sv, tag, "sv_valid", 32'(sv_valid), 32'(e_sv));
    chk(sv_info == m_info, tag, "sv_info", 32'(sv_info), 32'(m_info));
    chk(sv_pc == m_spc, tag, "sv_pc", sv_pc, m_spc);
    @(posedge clk);
    if (take) begin
      m_en = 1'b0; m_spc = pc_cur; m_info = irq_info;
    end else if (go) begin
      case (cmd_op)
        5'd29, 5'd10: m_en = 1'b1;
        5'd11:        m_en = 1'b0;
        5'd17:        begin m_info = cmd_a; m_spc = cmd_b; end
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle();
    irq_req = 0; fetch_start = 0; cmd_valid = 0;
  endtask

  task automatic cmd(input logic [4:0] op, input logic [15:0] a, input logic [31:0] b);
    cmd_valid = 1; cmd_op = op; cmd_a = a; cmd_b = b;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    m_en = 0; m_spc = '0; m_info = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    idle(); cycle("R1");
    // R5: request at a fetch boundary while disabled
    irq_req = 1; fetch_start = 1; irq_type = 8'h3C; irq_info = 16'hBEEF; pc_cur = 32'h100;
    cycle("R5"); idle(); cycle("R5");
    // R8: enable
    cmd(5'd10, '0, '0); cycle("R8"); idle();
    // R6: request between fetch boundaries
    irq_req = 1; cycle("R6"); cycle("R6");
    // R2/R3: entry
    fetch_start = 1; pc_cur = 32'h0000_1234; irq_info = 16'hA55A; irq_type = 8'hFF;
    cycle("R2");
    // R4: held request and boundary, no second ack
    pc_cur = 32'h0000_0FF0; cycle("R4"); idle(); cycle("R3");
    // R9: save state
    cmd(5'd16, '0, '0); cycle("R9"); idle();
    // R10: restore state
    cmd(5'd17, 16'h1357, 32'hCAFE_0008); cycle("R10"); idle(); cycle("R10");
    // R7: return with a pending request at the same boundary
    cmd(5'd29, '0, '0); irq_req = 1; fetch_start = 1; irq_type = 8'h00;
    cycle("R7"); idle(); cycle("R7");
    // R2: type 0x00 entry
    irq_req = 1; fetch_start = 1; irq_type = 8'h00; pc_cur = 32'h2000; cycle("R2"); idle();
    // R8: disable after enable
    cmd(5'd10, '0, '0); cycle("R8"); cmd(5'd11, '0, '0); cycle("R8"); idle(); cycle("R8");
    // R11: unrelated opcode and invalid command
    cmd(5'd5, 16'hFFFF, 32'hFFFF_FFFF); cycle("R11");
    cmd_valid = 0; cmd_op = 5'd17; cycle("R11"); idle();
    // R11: entry beats a restore in the same cycle
    cmd(5'd10, '0, '0); cycle("R11");
    cmd(5'd17, 16'h0F0F, 32'h1111_0000); irq_req = 1; fetch_start = 1;
    irq_type = 8'h81; pc_cur = 32'h3000; irq_info = 16'h7777; cycle("R11"); idle(); cycle("R11");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [4:0] ops [6];
      ops = '{5'd29, 5'd10, 5'd11, 5'd16, 5'd17, 5'd3};
      irq_req = $urandom_range(0, 1); fetch_start = $urandom_range(0, 1);
      irq_type = 8'($urandom); irq_info = 16'($urandom); pc_cur = $urandom;
      cmd_valid = ($urandom_range(0, 2) == 0);
      cmd_op = ops[$urandom_range(0, 5)]; cmd_a = 16'($urandom); cmd_b = $urandom;
      cycle("R2");
    end
    done = 1;
    report();
  end
endmodule